// File: doc/BRIEF.md
# Interrupt acknowledge and completion tracker

This block is the sequencing core of a processor-facing interrupt interface. It answers acknowledge requests and handles end-of-interrupt requests. It tracks which interrupt is currently being serviced (the running ID) and the priority level that goes with it. When a more urgent interrupt preempts the one in service, the tracker records the interrupted ID in a per-line back-pointer. The in-service interrupts therefore form a linked list, with the innermost one at the head.

An external priority resolver supplies the highest-pending ID and that ID's priority. The resolver is not part of this block. The block also receives per-line level, trigger-type and enable state, plus a flat table of per-line priorities. It returns these outputs to the surrounding logic:
- one-hot strobes that clear or set pending bits,
- the running ID and running priority,
- a pulse that drops the interrupt line to the processor.

Completions may arrive in any order. Completing the head interrupt pops the list. Completing an interrupt further down starts a multi-cycle walk that unlinks it from the list. While the walk runs, `busy` is high and new requests are refused.

Top module: `ack_eoi_tracker`

## Requirements
- R1: After reset the running ID is 1023 and the running priority is 0x100. `busy`, `ackValid`, `irqDrop`, `pendClr` and `pendSet` are all zero.
- R2: An acknowledge is rejected when `hpId` is 1023, or when {0,`hpPrio`} is not strictly below the running priority. After the sampling edge, `ackValid` is 1 with `ackId` = 1023, and `irqDrop` and `pendClr` are zero. The running state is unchanged.
- R3: An acknowledge is granted in all other cases. After the sampling edge:
  - `ackValid` is 1 and `ackId` = `hpId`;
  - `pendClr` has exactly bit `hpId` set and `irqDrop` pulses for one cycle;
  - the running ID becomes `hpId` and the running priority becomes {0,`hpPrio`}.
- R4: A completion whose ID equals the running ID restores the ID that this line preempted. The running priority is reloaded from `linePrio` for that restored line, where line k's priority sits at bits [k*8 +: 8].
- R5: Whenever the running ID is restored to 1023, the running priority becomes 0x100.
- R6: A completion request while the running ID is 1023 has no effect: no `pendSet` and no change in running state.
- R7: On an accepted completion of line k, `pendSet` has exactly bit k set for one cycle when all three hold: `lineEdge[k]` = 0 (level type), `lineEnable[k]` = 1 and `lineLevel[k]` = 1. Otherwise `pendSet` stays zero.
- R8: A completion whose ID is not the running ID raises `busy` on the next cycle. The block then walks the list from the head, one link per cycle, and unlinks the completed ID wherever it is found. The running ID and priority do not change, and later completions skip the removed line.
- R9: A walk ends after one cycle per link visited, and never takes more than the line count in cycles. While `busy` is high, acknowledge and completion requests are not accepted and produce no response.
- R10: When an acknowledge and a completion are requested in the same idle cycle, only the completion is served. No `ackValid` follows, and the requester repeats the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ackReq | input | 1 | Acknowledge request, sampled on a rising edge |
| hpId | input | 10 | Highest-pending ID from the resolver (1023 means none) |
| hpPrio | input | 8 | Priority of `hpId` |
| eoiReq | input | 1 | End-of-interrupt request |
| eoiId | input | 10 | ID being completed |
| linePrio | input | NUM_LINES*8 | Per-line priority table |
| lineLevel | input | NUM_LINES | Current input level of each line |
| lineEdge | input | NUM_LINES | 1 = edge-type line, 0 = level-type line |
| lineEnable | input | NUM_LINES | Per-line enable |
| busy | output | 1 | Walk in progress; requests are refused |
| ackValid | output | 1 | One-cycle acknowledge response strobe |
| ackId | output | 10 | Acknowledged ID, or 1023 on rejection |
| runId | output | 10 | Running ID |
| runPrio | output | 9 | Running priority (0x100 when idle) |
| pendClr | output | NUM_LINES | One-hot pending-clear strobe |
| pendSet | output | NUM_LINES | One-hot pending-set strobe |
| irqDrop | output | 1 | One-cycle pulse that drops the processor interrupt |

## Verification
Acknowledge and completion can be requested in the same cycle. The bench provokes this by raising both requests together while a level-type line is running with its input still high. It then expects three things after the edge:
- the running ID falls back to 1023 with priority 0x100;
- the re-pend strobe fires for that line;
- no acknowledge response appears.

The scoreboard monitor treats any `ackValid` with no queued expectation as a failure. The same monitor also watches for stray responses while an acknowledge request is held high through a three-link walk.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_ID = 10'd1023;

  typedef struct packed {
    logic grant;
    logic reject;
    logic pop;
    logic repend;
    logic walkStart;
    logic walkStep;
    logic splice;
  } trkCmd_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } trkState_t;
endpackage

// File: rtl/trk_ctrl.sv
module trk_ctrl
  import trk_pkg::*;
#(
  parameter int NUM_LINES = 96
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ackReq,
  input  logic    eoiReq,
  input  logic    hpOk,
  input  logic    runIdle,
  input  logic    eoiIsRun,
  input  logic    repOk,
  input  logic    stepEnd,
  input  logic    stepHit,
  output trkCmd_t cmd,
  output logic    busy
);
  localparam int CNT_W = $clog2(NUM_LINES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_LINES - 1);

  trkState_t state, stateNxt;
  logic [CNT_W-1:0] walkCnt;

  always_comb begin
    cmd = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (eoiReq) begin
          if (!runIdle) begin
            cmd.repend = repOk;
            if (eoiIsRun) begin
              cmd.pop = 1'b1;
            end else begin
              cmd.walkStart = 1'b1;
              stateNxt = ST_WALK;
            end
          end
        end else if (ackReq) begin
          cmd.grant  = hpOk;
          cmd.reject = !hpOk;
        end
      end
      ST_WALK: begin
        if (stepEnd) begin
          stateNxt = ST_IDLE;
        end else if (stepHit) begin
          cmd.splice = 1'b1;
          stateNxt = ST_IDLE;
        end else if (walkCnt == CNT_LAST) begin
          stateNxt = ST_IDLE;
        end else begin
          cmd.walkStep = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      walkCnt <= '0;
    end else begin
      state   <= stateNxt;
      walkCnt <= (state == ST_WALK && stateNxt == ST_WALK) ? walkCnt + 1'b1 : '0;
    end
  end

  assign busy = (state == ST_WALK);

  AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (walkCnt < CNT_W'(NUM_LINES))); // R9
  AST_SPLICE_ENDS_WALK: assert property (@(posedge clk) disable iff (!rstN)
    cmd.splice |=> !busy); // R8
endmodule

// File: rtl/trk_datapath.sv
module trk_datapath
  import trk_pkg::*;
#(
  parameter int NUM_LINES = 96,
  parameter int PRIO_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  trkCmd_t                     cmd,
  input  logic [ID_W-1:0]             hpId,
  input  logic [PRIO_W-1:0]           hpPrio,
  input  logic [ID_W-1:0]             eoiId,
  input  logic [NUM_LINES*PRIO_W-1:0] linePrio,
  input  logic [NUM_LINES-1:0]        lineLevel,
  input  logic [NUM_LINES-1:0]        lineEdge,
  input  logic [NUM_LINES-1:0]        lineEnable,
  output logic                        hpOk,
  output logic                        runIdle,
  output logic                        eoiIsRun,
  output logic                        repOk,
  output logic                        stepEnd,
  output logic                        stepHit,
  output logic [ID_W-1:0]             runId,
  output logic [PRIO_W:0]             runPrio,
  output logic                        ackValid,
  output logic [ID_W-1:0]             ackId,
  output logic [NUM_LINES-1:0]        pendClr,
  output logic [NUM_LINES-1:0]        pendSet,
  output logic                        irqDrop
);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};
  localparam logic [ID_W-1:0] LINE_LIM  = ID_W'(NUM_LINES);

  logic [ID_W-1:0]   prevId [NUM_LINES];
  logic [PRIO_W-1:0] prioArr [NUM_LINES];
  logic [ID_W-1:0]   cursor, targetId;
  logic [ID_W-1:0]   cursorNext, eoiNext, targetNext;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gPrio
    assign prioArr[g] = linePrio[g*PRIO_W +: PRIO_W];
  end

  function automatic logic [ID_W-1:0] chainAt(input logic [ID_W-1:0] id);
    logic [ID_W-1:0] r;
    r = NO_ID;
    for (int k = 0; k < NUM_LINES; k++)
      if (id == ID_W'(k)) r = prevId[k];
    return r;
  endfunction

  function automatic logic [PRIO_W:0] prioOf(input logic [ID_W-1:0] id);
    logic [PRIO_W:0] r;
    r = IDLE_PRIO;
    for (int k = 0; k < NUM_LINES; k++)
      if (id == ID_W'(k)) r = {1'b0, prioArr[k]};
    return r;
  endfunction

  function automatic logic [NUM_LINES-1:0] decode(input logic [ID_W-1:0] id);
    logic [NUM_LINES-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_LINES; k++)
      if (id == ID_W'(k)) r[k] = 1'b1;
    return r;
  endfunction

  function automatic logic bitAt(input logic [NUM_LINES-1:0] v, input logic [ID_W-1:0] id);
    return |(v & decode(id));
  endfunction

  always_comb begin
    cursorNext = chainAt(cursor);
    eoiNext    = chainAt(eoiId);
    targetNext = chainAt(targetId);
    hpOk       = (hpId != NO_ID) && (hpId < LINE_LIM) && ({1'b0, hpPrio} < runPrio);
    runIdle    = (runId == NO_ID);
    eoiIsRun   = (eoiId == runId);
    repOk      = (eoiId < LINE_LIM) && !bitAt(lineEdge, eoiId) &&
                 bitAt(lineEnable, eoiId) && bitAt(lineLevel, eoiId);
    stepEnd    = (cursorNext == NO_ID);
    stepHit    = (cursorNext == targetId);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runId    <= NO_ID;
      runPrio  <= IDLE_PRIO;
      ackValid <= 1'b0;
      ackId    <= NO_ID;
      irqDrop  <= 1'b0;
      pendClr  <= '0;
      pendSet  <= '0;
      cursor   <= NO_ID;
      targetId <= NO_ID;
    end else begin
      ackValid <= cmd.grant | cmd.reject;
      irqDrop  <= cmd.grant;
      pendClr  <= cmd.grant ? decode(hpId) : '0;
      pendSet  <= cmd.repend ? decode(eoiId) : '0;
      if (cmd.grant) ackId <= hpId;
      else if (cmd.reject) ackId <= NO_ID;
      if (cmd.grant) begin
        runId   <= hpId;
        runPrio <= {1'b0, hpPrio};
      end else if (cmd.pop) begin
        runId   <= eoiNext;
        runPrio <= prioOf(eoiNext);
      end
      if (cmd.walkStart) begin
        cursor   <= runId;
        targetId <= eoiId;
      end else if (cmd.walkStep) begin
        cursor <= cursorNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_LINES; k++) prevId[k] <= NO_ID;
    end else begin
      for (int k = 0; k < NUM_LINES; k++) begin
        if (cmd.grant && hpId == ID_W'(k)) prevId[k] <= runId;
        else if (cmd.splice && cursor == ID_W'(k)) prevId[k] <= targetNext;
      end
    end
  end

  AST_DROP_WITH_CLR: assert property (@(posedge clk) disable iff (!rstN)
    irqDrop |-> ($countones(pendClr) == 1)); // R3
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pendClr)); // R3
  AST_SET_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pendSet)); // R7
  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rstN)
    (runId == NO_ID) |-> (runPrio == IDLE_PRIO)); // R5
  AST_GRANT_RAISES_URGENCY: assert property (@(posedge clk) disable iff (!rstN)
    cmd.grant |=> (runPrio < $past(runPrio))); // R3
endmodule

// File: rtl/ack_eoi_tracker.sv
module ack_eoi_tracker
  import trk_pkg::*;
#(
  parameter int NUM_LINES = 96,
  parameter int PRIO_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ackReq,
  input  logic [9:0]                  hpId,
  input  logic [PRIO_W-1:0]           hpPrio,
  input  logic                        eoiReq,
  input  logic [9:0]                  eoiId,
  input  logic [NUM_LINES*PRIO_W-1:0] linePrio,
  input  logic [NUM_LINES-1:0]        lineLevel,
  input  logic [NUM_LINES-1:0]        lineEdge,
  input  logic [NUM_LINES-1:0]        lineEnable,
  output logic                        busy,
  output logic                        ackValid,
  output logic [9:0]                  ackId,
  output logic [9:0]                  runId,
  output logic [PRIO_W:0]             runPrio,
  output logic [NUM_LINES-1:0]        pendClr,
  output logic [NUM_LINES-1:0]        pendSet,
  output logic                        irqDrop
);
  trkCmd_t cmd;
  logic hpOk, runIdle, eoiIsRun, repOk, stepEnd, stepHit;

  trk_ctrl #(.NUM_LINES(NUM_LINES)) uCtrl (
    .clk(clk), .rstN(rstN), .ackReq(ackReq), .eoiReq(eoiReq),
    .hpOk(hpOk), .runIdle(runIdle), .eoiIsRun(eoiIsRun), .repOk(repOk),
    .stepEnd(stepEnd), .stepHit(stepHit), .cmd(cmd), .busy(busy)
  );

  trk_datapath #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hpId(hpId), .hpPrio(hpPrio),
    .eoiId(eoiId), .linePrio(linePrio), .lineLevel(lineLevel),
    .lineEdge(lineEdge), .lineEnable(lineEnable), .hpOk(hpOk),
    .runIdle(runIdle), .eoiIsRun(eoiIsRun), .repOk(repOk),
    .stepEnd(stepEnd), .stepHit(stepHit), .runId(runId), .runPrio(runPrio),
    .ackValid(ackValid), .ackId(ackId), .pendClr(pendClr),
    .pendSet(pendSet), .irqDrop(irqDrop)
  );

  AST_WALK_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(runId)); // R8
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !ackValid); // R9
  AST_IDLE_EOI_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (eoiReq && !busy && runId == NO_ID) |=> (pendSet == '0 && $stable(runId))); // R6
endmodule

// File: tb/tb_ack_eoi_tracker.sv
module tb_ack_eoi_tracker;
  localparam int NL = 96;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ackReq = 1'b0, eoiReq = 1'b0;
  logic [9:0] hpId = 10'd1023, eoiId = 10'd0;
  logic [PW-1:0] hpPrio = '0;
  logic [NL*PW-1:0] linePrio = '0;
  logic [NL-1:0] lineLevel = '0, lineEdge = '0, lineEnable = '0;
  logic busy, ackValid, irqDrop;
  logic [9:0] ackId, runId;
  logic [PW:0] runPrio;
  logic [NL-1:0] pendClr, pendSet;

  int errors = 0;
  int checks = 0;
  logic [9:0] expQ[$];

  ack_eoi_tracker #(.NUM_LINES(NL), .PRIO_W(PW)) dut (
    .clk(clk), .rstN(rstN), .ackReq(ackReq), .hpId(hpId), .hpPrio(hpPrio),
    .eoiReq(eoiReq), .eoiId(eoiId), .linePrio(linePrio), .lineLevel(lineLevel),
    .lineEdge(lineEdge), .lineEnable(lineEnable), .busy(busy),
    .ackValid(ackValid), .ackId(ackId), .runId(runId), .runPrio(runPrio),
    .pendClr(pendClr), .pendSet(pendSet), .irqDrop(irqDrop)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] oneHot(input int line);
    logic [NL-1:0] v;
    v = '0;
    if (line >= 0) v[line] = 1'b1;
    return v;
  endfunction

  // Scoreboard monitor: each acknowledge response is compared with the queue head
  always @(negedge clk) begin
    if (rstN && ackValid) begin
      if (expQ.size() == 0) begin
        chk("R9/R10", "unexpected ackValid", 128'(ackId), 128'h0);
      end else begin
        logic [9:0] e;
        e = expQ.pop_front();
        chk("R2/R3", "ackId", 128'(ackId), 128'(e));
      end
    end
  end

  task automatic doAck(input int id, input int prio, input bit grant, input string req);
    logic [9:0] oldRun;
    logic [PW:0] oldPrio;
    @(negedge clk);
    oldRun = runId;
    oldPrio = runPrio;
    hpId = 10'(id);
    hpPrio = PW'(prio);
    ackReq = 1'b1;
    expQ.push_back(grant ? 10'(id) : 10'd1023);
    @(negedge clk);
    ackReq = 1'b0;
    chk(req, "irqDrop", 128'(irqDrop), 128'(grant));
    chk(req, "pendClr", 128'(pendClr), grant ? 128'(oneHot(id)) : 128'h0);
    chk(req, "runId", 128'(runId), grant ? 128'(id) : 128'(oldRun));
    chk(req, "runPrio", 128'(runPrio), grant ? 128'(prio) : 128'(oldPrio));
  endtask

  task automatic doEoi(input int id, input int setLine, input int expBusy,
                       input int expRun, input int expPrio, input string req);
    int n;
    @(negedge clk);
    eoiId = 10'(id);
    eoiReq = 1'b1;
    @(negedge clk);
    eoiReq = 1'b0;
    chk(req, "pendSet", 128'(pendSet), 128'(oneHot(setLine)));
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk(req, "busy cycles", 128'(n), 128'(expBusy));
    chk(req, "runId", 128'(runId), 128'(expRun));
    chk(req, "runPrio", 128'(runPrio), 128'(expPrio));
  endtask

  task automatic setPrio(input int line, input int p);
    linePrio[line*PW +: PW] = PW'(p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    setPrio(5, 'h40); setPrio(9, 'h20); setPrio(12, 'h10); setPrio(20, 'h50);
    setPrio(30, 'h30); setPrio(31, 'h28); setPrio(32, 'h20);
    lineEdge[12] = 1'b1;
    lineLevel[9] = 1'b1; lineEnable[9] = 1'b1;
    lineLevel[12] = 1'b1; lineEnable[12] = 1'b1;
    lineLevel[5] = 1'b1; lineEnable[5] = 1'b1;
    lineLevel[20] = 1'b1; lineEnable[20] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "runId", 128'(runId), 128'd1023);
    chk("R1", "runPrio", 128'(runPrio), 128'h100);
    chk("R1", "busy/ack/drop", 128'({busy, ackValid, irqDrop}), 128'h0);
    chk("R1", "strobes", 128'({pendClr, pendSet}), 128'h0);

    doAck(1023, 0, 1'b0, "R2");           // nothing pending
    doAck(5, 'h40, 1'b1, "R3");           // first grant
    doAck(7, 'h40, 1'b0, "R2");           // equal priority is rejected
    doAck(9, 'h20, 1'b1, "R3");           // nested
    doAck(12, 'h10, 1'b1, "R3");          // nested deeper: 12 -> 9 -> 5
    // R8: out-of-order completion of 9, one link walked; R7 level line re-pended
    doEoi(9, 9, 1, 12, 'h10, "R8");
    // R4: head pop skips the spliced 9; edge-type line 12 not re-pended (R7)
    doEoi(12, -1, 0, 5, 'h40, "R4");

    // R10: acknowledge and completion requested together; completion wins
    @(negedge clk);
    hpId = 10'd33; hpPrio = 8'h01;
    ackReq = 1'b1; eoiReq = 1'b1; eoiId = 10'd5;
    @(negedge clk);
    ackReq = 1'b0; eoiReq = 1'b0;
    chk("R10", "ackValid", 128'(ackValid), 128'h0);
    chk("R5", "runId", 128'(runId), 128'd1023);
    chk("R5", "runPrio", 128'(runPrio), 128'h100);
    chk("R7", "pendSet", 128'(pendSet), 128'(oneHot(5)));

    // R6: completion while idle is ignored
    doEoi(5, -1, 0, 1023, 'h100, "R6");

    // R7: disabled level line not re-pended
    doAck(20, 'h50, 1'b1, "R3");
    doEoi(20, -1, 0, 1023, 'h100, "R7");

    // R9: three-link walk with an acknowledge held during busy
    doAck(30, 'h30, 1'b1, "R3");
    doAck(31, 'h28, 1'b1, "R3");
    doAck(32, 'h20, 1'b1, "R3");
    begin
      int n;
      @(negedge clk);
      eoiId = 10'd40; eoiReq = 1'b1;
      @(negedge clk);
      eoiReq = 1'b0;
      hpId = 10'd33; hpPrio = 8'h01; ackReq = 1'b1;
      n = 0;
      while (busy && n < 200) begin
        n++;
        @(negedge clk);
      end
      ackReq = 1'b0;
      chk("R9", "busy cycles", 128'(n), 128'd3);
      chk("R9", "runId held", 128'(runId), 128'd32);
      chk("R9", "irqDrop", 128'(irqDrop), 128'h0);
    end
    doEoi(32, -1, 0, 31, 'h28, "R4");
    doEoi(31, -1, 0, 30, 'h30, "R4");
    doEoi(30, -1, 0, 1023, 'h100, "R5");

    repeat (2) @(negedge clk);
    chk("R2/R3", "scoreboard drained", 128'(expQ.size()), 128'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule